// File: doc/BRIEF.md
# SCSI Bus Reset Controller

This block runs bus reset for a SCSI protocol controller. A reset episode starts in one of two ways. Another device can pull the shared active-low RST line low. The host can also issue a reset-bus command, in which case the block drives RST low for a fixed time of about 25 microseconds. The pulse length is a clock-cycle count that the block works out from a clock-frequency parameter and a pulse-length parameter.

During every episode the block produces one soft-reset strobe. That strobe clears these neighbouring logic blocks:

- the DMA interface;
- the logic that handles selection and reselection started by the bus;
- the command sequencer;
- the disconnect, initiator and target command modules.

The same strobe also:

- zeroes the sequence step and the three sequencer mode bits;
- flushes the command FIFO;
- releases every SCSI output except RST;
- forces the link to the disconnected state.

The block also raises a reset interrupt that the host can mask. If the host clears that interrupt while the bus is still in reset, the interrupt is raised again at once, so an episode that is still active cannot go unnoticed.

The bus line first passes through a two-flop synchroniser. The block's own drive of RST comes back through that same line. As a result, a reset that the block started itself appears on the bus input two clocks after the drive begins.

Top module: `scsiBusReset`

## Requirements
- R1: While the hard reset `rstN` is low, and in the first cycle after it is released, every output is 0.
- R2: When `scsiRstN` is sampled low, the soft-reset outputs go high in the third cycle, counted from the first clock edge that sees the line low (one edge for each synchroniser flop plus one edge for the output register).
- R3: For a reset coming from the bus, the soft-reset outputs stay high for exactly L+1 consecutive cycles, where L is the number of clock edges that sampled the line low.
- R4: The following outputs are always equal to each other in every cycle: every bit of `subRst`, plus `seqClr`, `fifoFlush`, `sigRelease` and `linkDisc`. The bit order of `subRst` is: 0 DMA, 1 bus-initiated select/reselect, 2 command sequencer, 3 disconnect, 4 initiator, 5 target.
- R5: A `cmdResetBus` strobe sampled while the block is not driving sets `rstDriveEn` high from the next cycle. It stays high for exactly CLK_HZ/1000000*PULSE_US cycles (3125 with the default parameters).
- R6: A `cmdResetBus` strobe sampled while `rstDriveEn` is high is ignored and does not restart or lengthen the pulse.
- R7: A command-started reset raises the soft-reset outputs in the cycle after the command. They stay high without a gap until three cycles after `rstDriveEn` falls (pulse length + 4 cycles in total, when no other device drives the line). `rstDriveEn` high always implies `linkDisc` high.
- R8: Each new reset episode, from either source, sets `intReq` in the same cycle that the soft-reset outputs rise, unless `cfgIntDisable` is 1. While `cfgIntDisable` is 1, a low `intReq` stays low.
- R9: Once set, `intReq` stays high until an `intClr` strobe arrives.
- R10: If `intClr` arrives while the synchronised bus reset is deasserted, `intReq` is 0 in the next cycle. If it arrives while the synchronised bus reset is asserted and `cfgIntDisable` is 0, `intReq` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hard reset, active low, asynchronous |
| scsiRstN | input | 1 | SCSI RST line as seen on the bus, active low |
| cmdResetBus | input | 1 | Host reset-bus command strobe |
| cfgIntDisable | input | 1 | Configuration bit; 1 disables the reset interrupt |
| intClr | input | 1 | Host strobe that clears the interrupt |
| rstDriveEn | output | 1 | Drives the RST line low while high |
| intReq | output | 1 | Reset interrupt request |
| subRst | output | NUM_SUB (6) | Reset strobes, one per cleared module |
| seqClr | output | 1 | Zeroes the sequence step and the sequencer mode bits |
| fifoFlush | output | 1 | Empties the command FIFO |
| sigRelease | output | 1 | Releases all SCSI outputs except RST |
| linkDisc | output | 1 | Forces the link state to disconnected |

## Verification
The assertions check the following on every cycle:

- a driven pulse always implies an active soft reset;
- the soft reset follows the synchronised bus reset and outlasts it by one clock;
- the interrupt holds until it is cleared;
- a clear wins when the bus is idle and re-arms when the bus is still in reset;
- a masked, low interrupt stays low.

Three behaviours can only be shown by the bench's scenarios, because each depends on a count over a whole episode: the exact pulse length, the fact that a repeated command leaves that length unchanged, and the L+1 and pulse+4 lengths of the soft reset. Random bus-reset episodes mixed with random clears and mask changes exercise the interrupt rules against a bench model.

// File: rtl/scsiRstPkg.sv
package scsiRstPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCnt;  // start a new pulse count
    logic decCnt;   // count one cycle of the pulse
  } cntStrobe_t;

  // Index of each cleared module in subRst
  localparam int SUB_DMA      = 0;
  localparam int SUB_BUSSEL   = 1;
  localparam int SUB_CMDSEQ   = 2;
  localparam int SUB_DISC     = 3;
  localparam int SUB_INIT     = 4;
  localparam int SUB_TARG     = 5;
  localparam int NUM_SUB      = 6;

endpackage

// File: rtl/scsiRstDp.sv
module scsiRstDp
  import scsiRstPkg::*;
#(
  parameter int PULSE_CYCLES = 3125,
  parameter int CW = $clog2(PULSE_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scsiRstN,
  input  cntStrobe_t stb,
  output logic       busRstSync,
  output logic       busRstHold,
  output logic       cntZero
);

  logic          syncA;
  logic          syncB;
  logic          holdQ;
  logic [CW-1:0] cnt;

  // Two-flop synchroniser; stored as active-high "bus in reset"
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      holdQ <= 1'b0;
    end else begin
      syncA <= ~scsiRstN;
      syncB <= syncA;
      holdQ <= syncB;
    end
  end

  // Pulse length counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.loadCnt) begin
      cnt <= CW'(PULSE_CYCLES - 1);
    end else if (stb.decCnt && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busRstSync = syncB;
  assign busRstHold = holdQ;
  assign cntZero    = (cnt == '0);

endmodule

// File: rtl/scsiRstCtrl.sv
module scsiRstCtrl
  import scsiRstPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busRstSync,
  input  logic       busRstHold,
  input  logic       cntZero,
  input  logic       cmdResetBus,
  input  logic       cfgIntDisable,
  input  logic       intClr,
  output cntStrobe_t stb,
  output logic       rstDriveEn,
  output logic       softRst,
  output logic       intReq
);

  logic driveQ;
  logic softQ;
  logic intQ;
  logic cmdAccept;
  logic trigger;
  logic episodeStart;

  // A command is taken only when no pulse is running
  assign cmdAccept    = cmdResetBus & ~driveQ;
  assign trigger      = busRstSync | driveQ | cmdAccept;
  assign episodeStart = trigger & ~softQ;

  always_comb begin
    stb.loadCnt = cmdAccept;
    stb.decCnt  = driveQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveQ <= 1'b0;
    end else if (cmdAccept) begin
      driveQ <= 1'b1;
    end else if (driveQ && cntZero) begin
      driveQ <= 1'b0;
    end
  end

  // Soft reset is held while triggered, plus one clock of bus tail
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) softQ <= 1'b0;
    else       softQ <= trigger | busRstHold;
  end

  // Clear wins only when the bus reset is gone
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intQ <= 1'b0;
    end else if (intClr) begin
      intQ <= busRstSync & ~cfgIntDisable;
    end else if (episodeStart && !cfgIntDisable) begin
      intQ <= 1'b1;
    end
  end

  assign rstDriveEn = driveQ;
  assign softRst    = softQ;
  assign intReq     = intQ;

endmodule

// File: rtl/scsiBusReset.sv
module scsiBusReset
  import scsiRstPkg::*;
#(
  parameter int CLK_HZ   = 125_000_000,
  parameter int PULSE_US = 25
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               scsiRstN,
  input  logic               cmdResetBus,
  input  logic               cfgIntDisable,
  input  logic               intClr,
  output logic               rstDriveEn,
  output logic               intReq,
  output logic [NUM_SUB-1:0] subRst,
  output logic               seqClr,
  output logic               fifoFlush,
  output logic               sigRelease,
  output logic               linkDisc
);

  localparam int PULSE_CYCLES = (CLK_HZ / 1_000_000) * PULSE_US;
  localparam int CW           = $clog2(PULSE_CYCLES + 1);

  cntStrobe_t stb;
  logic       busRstSync;
  logic       busRstHold;
  logic       cntZero;
  logic       softRst;

  scsiRstDp #(
    .PULSE_CYCLES (PULSE_CYCLES),
    .CW           (CW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .scsiRstN   (scsiRstN),
    .stb        (stb),
    .busRstSync (busRstSync),
    .busRstHold (busRstHold),
    .cntZero    (cntZero)
  );

  scsiRstCtrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .busRstSync    (busRstSync),
    .busRstHold    (busRstHold),
    .cntZero       (cntZero),
    .cmdResetBus   (cmdResetBus),
    .cfgIntDisable (cfgIntDisable),
    .intClr        (intClr),
    .stb           (stb),
    .rstDriveEn    (rstDriveEn),
    .softRst       (softRst),
    .intReq        (intReq)
  );

  for (genvar g = 0; g < NUM_SUB; g++) begin : gSub
    assign subRst[g] = softRst;
  end

  assign seqClr     = softRst;
  assign fifoFlush  = softRst;
  assign sigRelease = softRst;
  assign linkDisc   = softRst;

endmodule

// File: rtl/scsiBusReset_chk.sv
module scsiBusReset_chk (
  input logic clk,
  input logic rstN,
  input logic busRstSync,
  input logic rstDriveEn,
  input logic linkDisc,
  input logic intReq,
  input logic intClr,
  input logic cfgIntDisable
);

  AST_DRIVE_IMPLIES_SOFT: assert property (@(posedge clk) disable iff (!rstN)
    rstDriveEn |-> linkDisc); // R7

  AST_SOFT_FOLLOWS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    busRstSync |=> linkDisc); // R3

  AST_SOFT_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busRstSync) |-> linkDisc); // R3

  AST_INT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !intClr) |=> intReq); // R9

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (intClr && !busRstSync) |=> !intReq); // R10

  AST_CLR_REARM: assert property (@(posedge clk) disable iff (!rstN)
    (intClr && busRstSync && !cfgIntDisable) |=> intReq); // R10

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cfgIntDisable && !intReq) |=> !intReq); // R8

endmodule

bind scsiBusReset scsiBusReset_chk u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .busRstSync    (busRstSync),
  .rstDriveEn    (rstDriveEn),
  .linkDisc      (linkDisc),
  .intReq        (intReq),
  .intClr        (intClr),
  .cfgIntDisable (cfgIntDisable)
);

// File: tb/scsiBusReset_tb.sv
module scsiBusReset_tb;

  localparam int CLK_HZ   = 125_000_000;
  localparam int PULSE_US = 2;
  localparam int P        = (CLK_HZ / 1_000_000) * PULSE_US;

  logic       clk = 1'b0;
  logic       rstN;
  logic       extLow;
  logic       cmdResetBus;
  logic       cfgIntDisable;
  logic       intClr;
  logic       rstDriveEn;
  logic       intReq;
  logic [5:0] subRst;
  logic       seqClr;
  logic       fifoFlush;
  logic       sigRelease;
  logic       linkDisc;
  logic       lineLow;
  logic       scsiRstN;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  // Wired bus line: low if another device or the block pulls it
  assign lineLow  = extLow | rstDriveEn;
  assign scsiRstN = ~lineLow;

  scsiBusReset #(.CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US)) u_dut (
    .clk           (clk),
    .rstN          (rstN),
    .scsiRstN      (scsiRstN),
    .cmdResetBus   (cmdResetBus),
    .cfgIntDisable (cfgIntDisable),
    .intClr        (intClr),
    .rstDriveEn    (rstDriveEn),
    .intReq        (intReq),
    .subRst        (subRst),
    .seqClr        (seqClr),
    .fifoFlush     (fifoFlush),
    .sigRelease    (sigRelease),
    .linkDisc      (linkDisc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Interrupt rule from R8 to R10
  function automatic logic expIntNext(logic cur, logic clr, logic bus, logic mask, logic start);
    if (clr) return bus & ~mask;
    if (start && !mask) return 1'b1;
    return cur;
  endfunction

  // Bench model of bus-only episodes (no commands), per R2, R3, R8-R10
  logic m1, m2, mHold, mSoft, mInt;
  always @(posedge clk) begin
    if (!rstN) begin
      m1 <= 0; m2 <= 0; mHold <= 0; mSoft <= 0; mInt <= 0;
    end else begin
      mInt  <= expIntNext(mInt, intClr, m2, cfgIntDisable, m2 & ~mSoft);
      m1    <= lineLow;
      m2    <= m1;
      mHold <= m2;
      mSoft <= m2 | mHold;
    end
  end

  function automatic bit allMatch();
    return (subRst == {6{linkDisc}}) && (seqClr == linkDisc) &&
           (fifoFlush == linkDisc) && (sigRelease == linkDisc);
  endfunction

  task automatic extEpisode(input int len, output int hi, output int lat);
    hi  = 0;
    lat = -1;
    @(negedge clk);
    extLow = 1'b1;
    for (int i = 0; i < len + 12; i++) begin
      if (i == len) extLow = 1'b0;
      @(negedge clk);
      if (linkDisc) begin
        hi++;
        if (lat < 0) lat = i + 1;
      end
      check(allMatch(), "R4", int'(subRst), int'({6{linkDisc}}));
    end
  endtask

  task automatic clearPulse();
    @(negedge clk);
    intClr = 1'b1;
    @(negedge clk);
    intClr = 1'b0;
  endtask

  initial begin
    int hi, lat, dc, lc, ended, gap, dummy;
    dummy = $urandom(32'd4242);
    rstN = 0; extLow = 0; cmdResetBus = 0; cfgIntDisable = 0; intClr = 0;
    repeat (3) @(negedge clk);
    check({rstDriveEn, intReq, linkDisc, subRst} == '0, "R1", int'({rstDriveEn, intReq, linkDisc}), 0);
    rstN = 1;
    @(negedge clk);
    check({rstDriveEn, intReq, linkDisc, subRst, seqClr, fifoFlush, sigRelease} == '0, "R1",
          int'({rstDriveEn, intReq, linkDisc}), 0);

    // Bus reset of 10 cycles
    extEpisode(10, hi, lat);
    check(lat == 3, "R2", lat, 3);
    check(hi == 11, "R3", hi, 11);
    check(intReq == 1'b1, "R8", intReq, 1);
    repeat (5) @(negedge clk);
    check(intReq == 1'b1, "R9", intReq, 1);
    clearPulse();
    check(intReq == 1'b0, "R10", intReq, 0);

    // Short bus reset of 1 cycle
    extEpisode(1, hi, lat);
    check(hi == 2, "R3", hi, 2);
    clearPulse();

    // Clear while bus reset is still active re-arms
    @(negedge clk);
    extLow = 1'b1;
    repeat (6) @(negedge clk);
    check(intReq == 1'b1, "R8", intReq, 1);
    intClr = 1'b1;
    @(negedge clk);
    intClr = 1'b0;
    check(intReq == 1'b1, "R10", intReq, 1);
    extLow = 1'b0;
    repeat (8) @(negedge clk);
    check(intReq == 1'b1, "R9", intReq, 1);
    clearPulse();
    check(intReq == 1'b0, "R10", intReq, 0);

    // Masked episode
    cfgIntDisable = 1'b1;
    extEpisode(7, hi, lat);
    check(hi == 8, "R3", hi, 8);
    check(intReq == 1'b0, "R8", intReq, 0);
    cfgIntDisable = 1'b0;
    repeat (3) @(negedge clk);

    // Host command pulse
    @(negedge clk);
    cmdResetBus = 1'b1;
    @(negedge clk);
    cmdResetBus = 1'b0;
    check(rstDriveEn == 1'b1, "R5", rstDriveEn, 1);
    check(linkDisc == 1'b1, "R7", linkDisc, 1);
    dc = 0; lc = 0; ended = 0; gap = 0;
    for (int i = 0; i < P + 20; i++) begin
      if (rstDriveEn) dc++;
      if (linkDisc) begin
        lc++;
        if (ended != 0) gap = 1;
      end else if (lc > 0) begin
        ended = 1;
      end
      @(negedge clk);
    end
    check(dc == P, "R5", dc, P);
    check(lc == P + 4, "R7", lc, P + 4);
    check(gap == 0, "R7", gap, 0);
    check(intReq == 1'b1, "R8", intReq, 1);
    clearPulse();
    check(intReq == 1'b0, "R10", intReq, 0);

    // Command repeated during a pulse is ignored
    @(negedge clk);
    cmdResetBus = 1'b1;
    @(negedge clk);
    cmdResetBus = 1'b0;
    dc = 0;
    for (int i = 0; i < P + 20; i++) begin
      if (i == 50) cmdResetBus = 1'b1;
      if (i == 51) cmdResetBus = 1'b0;
      if (rstDriveEn) dc++;
      @(negedge clk);
    end
    check(dc == P, "R6", dc, P);
    clearPulse();

    // Random bus episodes against the bench model
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(0, 5) == 0) extLow = ~extLow;
      intClr = ($urandom_range(0, 6) == 0);
      if ($urandom_range(0, 40) == 0) cfgIntDisable = ~cfgIntDisable;
      @(negedge clk);
      check(linkDisc == mSoft, "R3", linkDisc, mSoft);
      check(intReq == mInt, "R10", intReq, mInt);
      check(allMatch(), "R4", int'(subRst), int'({6{linkDisc}}));
    end
    extLow = 1'b0; intClr = 1'b0;
    repeat (5) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule